// File: doc/BRIEF.md
# Planar-Bit Pixel Serializer with Horizontal Scaling

This block turns one fetched display byte into a run of colour pixels. The byte is split into 8, 4 or 2 logical pixels according to the selected colour depth. At 2 and 4 bits per pixel, the bits of each pixel are gathered from interleaved bit positions rather than from adjacent fields. Each logical pixel passes through a fixed palette that keeps the low three bits of the colour. The palette result drives a 3-bit RGB output, and each pixel is repeated for 1, 2 or 4 output cycles.

A fetch engine upstream strobes each byte in as it arrives. The byte waits in a one-entry holding register until the pixel buffer is empty and a fetch slot begins. A free-running phase counter marks the slots, and phase 0 is the only phase at which a byte may be taken. The depth and scale inputs are sampled when a byte is taken. A blank request forces the output to black and freezes the pixel sequence while it is held.

Top module: `planar_pixel_serializer`

## Requirements
- R1: After reset, and whenever the pixel buffer is empty, `rgb` is 3'b000.
- R2: With depth code 0 (1 bpp), a byte yields 8 pixels: pixel k is bit (7-k) of the byte, so bit 7 comes out first.
- R3: With depth code 1 (2 bpp), a byte yields 4 pixels: pixel k (k=0..3) is {bit(7-k), bit(3-k)}, with the first bit as the MSB.
- R4: With depth code 2 or 3 (4 bpp), a byte yields 2 pixels: pixel k (k=0..1) is {bit(7-k), bit(5-k), bit(3-k), bit(1-k)}, with the first bit as the MSB.
- R5: A logical pixel c is shown as colour (c mod 8). rgb[0] is red and equals bit 0 of that colour, rgb[1] is green and equals bit 1, and rgb[2] is blue and equals bit 2.
- R6: Scale code 0 holds each pixel for 1 cycle, code 1 for 2 cycles, and codes 2 and 3 for 4 cycles.
- R7: After the last pixel of a byte has been held for its full time, the buffer is empty and the output returns to black.
- R8: A byte is taken from the holding register only in a cycle where the phase counter is 0 and the buffer is empty. The counter resets to 0 and advances once per clock, wrapping after SLOT_LEN cycles. The first pixel appears in the cycle after the byte is taken.
- R9: While `blank` is high, `rgb` is black, and the pixel being shown and its hold count do not advance. The sequence resumes where it stopped once `blank` falls.
- R10: If a second byte is strobed before a pending byte has been taken, the newer byte replaces the older one.
- R11: Depth and scale are captured when a byte is taken. Changing them while that byte is being shown does not alter its pixels or their hold times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| depth_sel | input | 2 | Colour depth code: 0 = 1 bpp, 1 = 2 bpp, 2 or 3 = 4 bpp |
| scale_sel | input | 2 | Pixel repeat code: 0 = x1, 1 = x2, 2 or 3 = x4 |
| pix_byte | input | 8 | Fetched display byte |
| byte_stb | input | 1 | One-cycle strobe marking `pix_byte` valid |
| blank | input | 1 | Blank request: forces black and pauses the pixel sequence |
| rgb | output | 3 | Pixel colour: bit 0 red, bit 1 green, bit 2 blue |

## Verification
The bench builds the block with its default slot length of 8 and keeps its own cycle count modulo 8. Because of this, it can strobe a byte at any chosen phase, including phase 0, which gives the longest wait before the byte is taken. All three depths and all four scale codes are reached. This includes the aliased codes 3, which exercise the 4-bpp interleave and the 4-cycle hold. Blank gaps are placed inside a running byte to check that the sequence pauses and resumes.

// File: rtl/pxser_pkg.sv
package pxser_pkg;

  localparam int BYTE_W  = 8;
  localparam int LPIX_W  = 4;
  localparam int RGB_W   = 3;
  localparam int IDX_W   = $clog2(BYTE_W);
  localparam int HOLD_W  = 2;

  // last pixel index for a depth code: 1 bpp -> 7, 2 bpp -> 3, 4 bpp -> 1
  function automatic logic [IDX_W-1:0] last_index(input logic [1:0] dep);
    case (dep)
      2'd0:    last_index = IDX_W'(BYTE_W - 1);
      2'd1:    last_index = IDX_W'(BYTE_W / 2 - 1);
      default: last_index = IDX_W'(BYTE_W / 4 - 1);
    endcase
  endfunction

  // hold time minus one for a scale code: x1 -> 0, x2 -> 1, x4 -> 3
  function automatic logic [HOLD_W-1:0] hold_limit(input logic [1:0] scl);
    case (scl)
      2'd0:    hold_limit = HOLD_W'(0);
      2'd1:    hold_limit = HOLD_W'(1);
      default: hold_limit = HOLD_W'(3);
    endcase
  endfunction

  // gather logical pixel k from interleaved bit positions
  function automatic logic [LPIX_W-1:0] pick_pixel(input logic [BYTE_W-1:0] b,
                                                    input logic [1:0] dep,
                                                    input logic [IDX_W-1:0] k);
    int i;
    i = int'(k);
    case (dep)
      2'd0:    pick_pixel = {3'b000, b[7 - i]};
      2'd1: begin
        i = i % 4;
        pick_pixel = {2'b00, b[7 - i], b[3 - i]};
      end
      default: begin
        i = i % 2;
        pick_pixel = {b[7 - i], b[5 - i], b[3 - i], b[1 - i]};
      end
    endcase
  endfunction

  // fixed palette: colour c maps to c mod 8, bit0 red, bit1 green, bit2 blue
  function automatic logic [RGB_W-1:0] palette_rgb(input logic [LPIX_W-1:0] c);
    palette_rgb = c[RGB_W-1:0];
  endfunction

endpackage

// File: rtl/pxser_slot_timer.sv
module pxser_slot_timer #(
  parameter int SLOT_LEN = 8,
  localparam int PH_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase,
  output logic            slot_start
);
  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              phase_q <= '0;
    else if (phase_q == PH_W'(SLOT_LEN - 1)) phase_q <= '0;
    else                                     phase_q <= phase_q + 1'b1;
  end

  assign phase      = phase_q;
  assign slot_start = (phase_q == '0);
endmodule

// File: rtl/pxser_byte_latch.sv
module pxser_byte_latch import pxser_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              byte_stb,
  input  logic              take,
  output logic [BYTE_W-1:0] held,
  output logic              pending
);
  logic [BYTE_W-1:0] held_q;
  logic              pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      pend_q <= 1'b0;
    end else if (byte_stb) begin
      held_q <= byte_in;
      pend_q <= 1'b1;
    end else if (take) begin
      pend_q <= 1'b0;
    end
  end

  assign held    = held_q;
  assign pending = pend_q;
endmodule

// File: rtl/pxser_shifter.sv
module pxser_shifter import pxser_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [1:0]        dep,
  input  logic [1:0]        scl,
  input  logic              blank,
  output logic              active,
  output logic [RGB_W-1:0]  rgb,
  output logic              pix_adv,
  output logic              last_done,
  output logic [IDX_W-1:0]  idx,
  output logic [HOLD_W-1:0] rep,
  output logic [HOLD_W-1:0] hold_lim
);
  logic [BYTE_W-1:0] buf_q;
  logic [1:0]        dep_q;
  logic [HOLD_W-1:0] hold_q, rep_q;
  logic [IDX_W-1:0]  last_q, idx_q;
  logic              active_q;
  logic              running;

  assign running   = active_q && !blank;
  assign pix_adv   = running && (rep_q == hold_q);
  assign last_done = pix_adv && (idx_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      dep_q    <= '0;
      hold_q   <= '0;
      last_q   <= '0;
      idx_q    <= '0;
      rep_q    <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      buf_q    <= byte_in;
      dep_q    <= dep;
      hold_q   <= hold_limit(scl);
      last_q   <= last_index(dep);
      idx_q    <= '0;
      rep_q    <= '0;
      active_q <= 1'b1;
    end else if (running) begin
      if (pix_adv) begin
        rep_q <= '0;
        if (last_done) active_q <= 1'b0;
        else           idx_q    <= idx_q + 1'b1;
      end else begin
        rep_q <= rep_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (running) rgb = palette_rgb(pick_pixel(buf_q, dep_q, idx_q));
    else         rgb = '0;
  end

  assign active   = active_q;
  assign idx      = idx_q;
  assign rep      = rep_q;
  assign hold_lim = hold_q;
endmodule

// File: rtl/planar_pixel_serializer.sv
module planar_pixel_serializer import pxser_pkg::*; #(
  parameter int SLOT_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       depth_sel,
  input  logic [1:0]       scale_sel,
  input  logic [7:0]       pix_byte,
  input  logic             byte_stb,
  input  logic             blank,
  output logic [2:0]       rgb
);
  localparam int PH_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;

  logic [PH_W-1:0]   phase;
  logic              slot_start;
  logic [BYTE_W-1:0] held;
  logic              pend;
  logic              active;
  logic              load_evt;
  logic              pix_adv;
  logic              last_done;
  logic [IDX_W-1:0]  idx;
  logic [HOLD_W-1:0] rep;
  logic [HOLD_W-1:0] hold_lim;

  assign load_evt = slot_start && pend && !active;

  pxser_slot_timer #(.SLOT_LEN(SLOT_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .phase(phase), .slot_start(slot_start)
  );

  pxser_byte_latch u_latch (
    .clk(clk), .rst_n(rst_n), .byte_in(pix_byte), .byte_stb(byte_stb),
    .take(load_evt), .held(held), .pending(pend)
  );

  pxser_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .byte_in(held),
    .dep(depth_sel), .scl(scale_sel), .blank(blank),
    .active(active), .rgb(rgb), .pix_adv(pix_adv), .last_done(last_done),
    .idx(idx), .rep(rep), .hold_lim(hold_lim)
  );
endmodule

// File: rtl/planar_pixel_serializer_chk.sv
module planar_pixel_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       blank,
  input logic       byte_stb,
  input logic [2:0] rgb,
  input logic       active,
  input logic       slot_start,
  input logic       pend,
  input logic       last_done,
  input logic [2:0] idx,
  input logic [1:0] rep,
  input logic [1:0] hold_lim
);
  // R1
  idle_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> rgb == 3'b000);

  // R9
  blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> rgb == 3'b000);

  // R9
  blank_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && blank) |=> ($stable(idx) && $stable(rep) && active));

  // R8
  load_at_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(slot_start && pend));

  // R6
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> rep <= hold_lim);

  // R7
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> !active);

  // R10
  strobe_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> pend);
endmodule

bind planar_pixel_serializer planar_pixel_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .blank(blank), .byte_stb(byte_stb), .rgb(rgb),
  .active(active), .slot_start(slot_start), .pend(pend),
  .last_done(last_done), .idx(idx), .rep(rep), .hold_lim(hold_lim)
);

// File: tb/sim_planar_pixel_serializer.sv
`timescale 1ns/100ps
module sim_planar_pixel_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] depth_sel = 2'd0;
  logic [1:0] scale_sel = 2'd0;
  logic [7:0] pix_byte = 8'd0;
  logic       byte_stb = 1'b0;
  logic       blank = 1'b0;
  logic [2:0] rgb;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  typedef struct {
    logic [2:0] exp;
    logic       blk;
    string      tag;
  } item_t;
  item_t q[$];

  planar_pixel_serializer u0 (
    .clk(clk), .rst_n(rst_n), .depth_sel(depth_sel), .scale_sel(scale_sel),
    .pix_byte(pix_byte), .byte_stb(byte_stb), .blank(blank), .rgb(rgb)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rgb=%b expected=%b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // monitor: pops one expected item per cycle, applies its blank level, compares
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      blank = it.blk;
      #1;
      check(it.tag, rgb, it.exp);
    end
  end

  function automatic logic [3:0] px_of(logic [31:0] pk, int k);
    return pk[31 - 4*k -: 4];
  endfunction

  // inverse of the interleave: place pixel bits at their positions
  function automatic logic [7:0] encode(logic [31:0] pk, logic [1:0] dep);
    logic [7:0] b;
    b = '0;
    if (dep == 2'd0) begin
      for (int k = 0; k < 8; k++) b[7-k] = px_of(pk, k)[0];
    end else if (dep == 2'd1) begin
      for (int k = 0; k < 4; k++) begin
        b[7-k] = px_of(pk, k)[1];
        b[3-k] = px_of(pk, k)[0];
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        b[7-k] = px_of(pk, k)[3];
        b[5-k] = px_of(pk, k)[2];
        b[3-k] = px_of(pk, k)[1];
        b[1-k] = px_of(pk, k)[0];
      end
    end
    return b;
  endfunction

  // driver: strobe a byte at phase ph, push the expected per-cycle colours
  task automatic run(string tg, logic [31:0] pk, logic [1:0] dep, logic [1:0] scl,
                     int ph, logic [31:0] bmask, bit dup, bit chg);
    int n, hold, target, j, k, r;
    item_t it;
    wait (q.size() == 0);
    repeat (4) @(negedge clk);
    n    = (dep == 2'd0) ? 8 : (dep == 2'd1) ? 4 : 2;
    hold = (scl == 2'd0) ? 1 : (scl == 2'd1) ? 2 : 4;
    target = dup ? ph - 1 : ph;
    while ((cyc % 8) != target) @(negedge clk);
    depth_sel = dep;
    scale_sel = scl;
    byte_stb  = 1'b1;
    if (dup) begin
      pix_byte = 8'hFF;
      @(negedge clk);
    end
    pix_byte = encode(pk, dep);
    @(posedge clk);
    #1 byte_stb = 1'b0;
    for (int i = 0; i < 8 - ph; i++) begin
      it.exp = 3'b000; it.blk = 1'b0; it.tag = "R8 wait for slot"; q.push_back(it);
    end
    j = 0; k = 0; r = 0;
    while (k < n) begin
      if (bmask[j]) begin
        it.exp = 3'b000; it.blk = 1'b1; it.tag = "R9 blank";
      end else begin
        it.exp = px_of(pk, k)[2:0]; it.blk = 1'b0; it.tag = tg;
        r++;
        if (r == hold) begin r = 0; k++; end
      end
      q.push_back(it);
      j++;
    end
    for (int i = 0; i < 2; i++) begin
      it.exp = 3'b000; it.blk = 1'b0; it.tag = "R7 idle after last"; q.push_back(it);
    end
    if (chg) begin
      repeat (8 - ph + 1) @(negedge clk);
      depth_sel = (dep == 2'd0) ? 2'd2 : 2'd0;
      scale_sel = (scl == 2'd0) ? 2'd2 : 2'd0;
    end
    wait (q.size() == 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check("R1 reset black", rgb, 3'b000);
    end
    run("R2 1bpp msb first",      {4'd1,4'd0,4'd1,4'd1,4'd0,4'd0,4'd1,4'd0}, 2'd0, 2'd0, 7, 32'd0, 1'b0, 1'b0);
    run("R3 2bpp interleave",     {4'd3,4'd1,4'd2,4'd0,16'd0},               2'd1, 2'd1, 7, 32'd0, 1'b0, 1'b0);
    run("R4 R5 4bpp palette",     {4'd9,4'd6,24'd0},                         2'd2, 2'd0, 7, 32'd0, 1'b0, 1'b0);
    run("R4 R6 code3 x4",         {4'd15,4'd10,24'd0},                       2'd3, 2'd3, 7, 32'd0, 1'b0, 1'b0);
    run("R6 1bpp x4",             {4'd1,4'd0,4'd0,4'd1,4'd1,4'd0,4'd1,4'd0}, 2'd0, 2'd2, 7, 32'd0, 1'b0, 1'b0);
    run("R5 2bpp colours",        {4'd1,4'd2,4'd3,4'd1,16'd0},               2'd1, 2'd0, 7, 32'd0, 1'b0, 1'b0);
    run("R8 strobe at phase 3",   {4'd2,4'd3,4'd0,4'd1,16'd0},               2'd1, 2'd0, 3, 32'd0, 1'b0, 1'b0);
    run("R8 strobe at phase 0",   {4'd1,4'd1,4'd0,4'd1,4'd0,4'd1,4'd0,4'd0}, 2'd0, 2'd0, 0, 32'd0, 1'b0, 1'b0);
    run("R9 resume after blank",  {4'd1,4'd0,4'd1,4'd0,4'd1,4'd1,4'd0,4'd1}, 2'd0, 2'd0, 7, 32'h0000_0608, 1'b0, 1'b0);
    run("R9 blank in x2 hold",    {4'd7,4'd4,24'd0},                         2'd2, 2'd1, 7, 32'h0000_0002, 1'b0, 1'b0);
    run("R10 newer byte wins",    {4'd0,4'd1,4'd1,4'd0,4'd1,4'd0,4'd0,4'd1}, 2'd0, 2'd0, 6, 32'd0, 1'b1, 1'b0);
    run("R11 mode held mid byte", {4'd3,4'd0,4'd2,4'd1,16'd0},               2'd1, 2'd1, 7, 32'd0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    #1 check("R1 idle black at end", rgb, 3'b000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule